// File: doc/BRIEF.md
# Fixed-Point Reciprocal Square Root Unit

This block returns 1/sqrt(a) for an unsigned 16-bit radicand. The radicand has 5 integer bits and 11 fraction bits, and the result uses the same format. Code 2048 therefore stands for 1.0, and code 65535 is just under 32.

A request enters through a single-cycle `start` strobe. It is taken only while `busy` is low. The unit then runs a fixed sequence of steps on one shared multiplier:

1. It moves the radicand by an even power of two into [0.5, 2).
2. It forms a seed from one of four quadratic segments.
3. It sharpens the seed with two division-free Newton steps of the form x·(3 − a·x²)/2.
4. It shifts the answer back by half the exponent and rounds to 16 bits.

Completion is a one-cycle `done` pulse. `result` and `overflow` are valid during that pulse and are held until the next request completes.

A result that cannot be represented raises `overflow` and returns 0xFFFF. This covers a zero radicand and any radicand whose rounded reciprocal root exceeds 65535.

Top module: `fxp_isqrt`

## Requirements
- R1: For every nonzero radicand code c whose value round(2048/sqrt(c/2048)) is at most 65535, the unit returns that value within ±1 code with `overflow` low.
- R2: When round(2048/sqrt(c/2048)) exceeds 65535 (radicand codes 1 and 2), `overflow` is 1 and `result` is 0xFFFF.
- R3: A zero radicand completes with `overflow` 1 and `result` 0xFFFF, and `done` rises 2 clock edges after the edge that accepts `start`.
- R4: `done` is high for exactly one cycle per accepted request, and `busy` is high whenever `done` is high.
- R5: A request is accepted only when `start` is high while `busy` is low. `busy` is high in the cycle after acceptance. A `start` seen while `busy` is high has no effect on the result or on the number of `done` pulses. This includes a `start` in the `done` cycle.
- R6: While `busy` is low, `result` and `overflow` keep their last values regardless of `radicand`.
- R7: For a nonzero radicand, `done` rises exactly 14 clock edges after the accepting edge (2 + 4 + 4 per Newton step, with 2 steps).
- R8: After synchronous reset, `busy`, `done` and `overflow` are 0 and `result` is 0.
- R9: Radicand code 4096 returns 1448 ±1, code 1024 returns 2896 ±1, and code 25344 returns 582 ±1.
- R10: Radicands that are 2048 times a power of four return the exact reciprocal root. Codes 8, 32, 128, 512, 2048, 8192 and 32768 give 32768, 16384, 8192, 4096, 2048, 1024 and 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe, taken when busy is low |
| radicand | input | 16 | Operand, unsigned, 11 fraction bits |
| busy | output | 1 | High from acceptance until the cycle after done |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Reciprocal root, unsigned, 11 fraction bits |
| overflow | output | 1 | Result not representable; result saturated |

## Verification
Two events can fall in the same cycle: the completion of one request and the arrival of the next `start`. The bench fires a second `start` part way through a computation. It also holds `start` high across the `done` cycle with a different radicand.

For both cases the bench expects three things:
- a single `done` pulse;
- the first operand's result;
- `busy` low in the following cycle, with the stale request never launched.

Around that, a near-exhaustive sweep compares every result against a reciprocal root computed in floating point by the bench.

// File: rtl/fxp_isqrt_pkg.sv
package fxp_isqrt_pkg;
  localparam int QF     = 28;            // internal fraction bits
  localparam int DW     = 32;            // internal datapath width
  localparam int SEGS   = 4;             // seed segments over [0.5,2)
  localparam int SEG_W  = $clog2(SEGS);

  typedef logic signed [DW-1:0] acc_t;
  typedef struct packed {
    acc_t c2;
    acc_t c1;
    acc_t c0;
  } coef_t;

  localparam real QSCALE = 2.0 ** QF;

  function automatic acc_t to_q(input real v);
    return acc_t'($rtoi(v * QSCALE));
  endfunction

  // p(s) = c0 + c1*s + c2*s^2, second-order expansion about segment centres
  // 0.625, 0.875, 1.25, 1.75
  localparam coef_t SEG_COEF [SEGS] = '{
    '{c2: to_q(1.214315), c1: to_q(-2.529823), c0: to_q(2.371709)},
    '{c2: to_q(0.523614), c1: to_q(-1.527208), c0: to_q(2.004460)},
    '{c2: to_q(0.214663), c1: to_q(-0.894428), c0: to_q(1.677052)},
    '{c2: to_q(0.092563), c1: to_q(-0.539950), c0: to_q(1.417368)}
  };

  localparam acc_t THREE_Q = acc_t'(3) <<< QF;

  typedef enum logic [2:0] {
    S_IDLE, S_NORM, S_SEED, S_ITER, S_DENORM, S_DONE
  } state_t;
endpackage

// File: rtl/fxp_isqrt_msb.sv
module fxp_isqrt_msb #(
  parameter int W  = 16,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          none
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) pos = PW'(i);
    end
  end
  assign none = (vec == '0);
endmodule

// File: rtl/fxp_isqrt_rom.sv
module fxp_isqrt_rom
  import fxp_isqrt_pkg::*;
(
  input  logic             clk,
  input  logic [SEG_W-1:0] seg,
  output coef_t            coef_q
);
  always_ff @(posedge clk) begin
    coef_q <= SEG_COEF[seg];
  end
endmodule

// File: rtl/fxp_isqrt_mul.sv
module fxp_isqrt_mul
  import fxp_isqrt_pkg::*;
(
  input  logic clk,
  input  acc_t op_a,
  input  acc_t op_b,
  output acc_t prod_q
);
  localparam int PW = 2 * DW;
  logic signed [PW-1:0] full;

  assign full = op_a * op_b;

  always_ff @(posedge clk) begin
    prod_q <= full[QF +: DW];
  end
endmodule

// File: rtl/fxp_isqrt.sv
module fxp_isqrt
  import fxp_isqrt_pkg::*;
#(
  parameter int WORD  = 16,
  parameter int FRAC  = 11,
  parameter int ITERS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [WORD-1:0] radicand,
  output logic            busy,
  output logic            done,
  output logic [WORD-1:0] result,
  output logic            overflow
);
  localparam int PW  = $clog2(WORD);
  localparam int SHB = QF - FRAC;       // shift from input format to internal
  localparam int SW  = $clog2(DW) + 1;
  localparam int IW  = $clog2(ITERS + 1);

  state_t          state;
  logic [1:0]      stp;
  logic [IW-1:0]   it;
  logic [WORD-1:0] a_q;
  acc_t            as_q, x_q;
  logic [SW-1:0]   dsh_q;
  logic            zero_q;

  // leading one of the captured radicand
  logic [PW-1:0] msb_pos;
  logic          msb_none;
  fxp_isqrt_msb #(.W(WORD), .PW(PW)) u_msb (
    .vec(a_q), .pos(msb_pos), .none(msb_none)
  );

  // even-exponent range reduction
  int            e_v, n_v;
  acc_t          as_nx;
  logic [SW-1:0] dsh_nx;
  always_comb begin
    e_v    = int'(msb_pos) - FRAC;
    n_v    = e_v[0] ? e_v + 1 : e_v;
    as_nx  = acc_t'(a_q) << (SHB - n_v);
    dsh_nx = SW'(SHB + (n_v >>> 1));
  end

  // segment pick from the scaled radicand
  logic [SEG_W-1:0] seg_idx;
  assign seg_idx = as_q[QF] ? {1'b1, as_q[QF-1]} : {1'b0, as_q[QF-2]};

  coef_t coef;
  fxp_isqrt_rom u_rom (.clk(clk), .seg(seg_idx), .coef_q(coef));

  // shared multiplier and its operand steering
  acc_t mul_a, mul_b, mul_p;
  always_comb begin
    mul_a = x_q;
    mul_b = x_q;
    if (state == S_SEED) begin
      if (stp == 2'd1) begin
        mul_a = coef.c2;
        mul_b = as_q;
      end else if (stp == 2'd2) begin
        mul_a = mul_p + coef.c1;
        mul_b = as_q;
      end
    end else if (state == S_ITER) begin
      if (stp == 2'd1) begin
        mul_a = as_q;
        mul_b = mul_p;
      end else if (stp == 2'd2) begin
        mul_a = x_q;
        mul_b = THREE_Q - mul_p;
      end
    end
  end

  fxp_isqrt_mul u_mul (.clk(clk), .op_a(mul_a), .op_b(mul_b), .prod_q(mul_p));

  // denormalise with round-half-up and saturation
  logic [DW:0] rnd_v, shf_v;
  logic        sat;
  assign rnd_v = {1'b0, x_q} + ((DW+1)'(1) << (dsh_q - 1'b1));
  assign shf_v = rnd_v >> dsh_q;
  assign sat   = zero_q || (shf_v > {{(DW+1-WORD){1'b0}}, {WORD{1'b1}}});

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      stp      <= '0;
      it       <= '0;
      a_q      <= '0;
      as_q     <= '0;
      x_q      <= '0;
      dsh_q    <= '0;
      zero_q   <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
      overflow <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            a_q   <= radicand;
            state <= S_NORM;
          end
        end
        S_NORM: begin
          zero_q <= msb_none;
          as_q   <= as_nx;
          dsh_q  <= dsh_nx;
          stp    <= '0;
          it     <= '0;
          state  <= msb_none ? S_DENORM : S_SEED;
        end
        S_SEED: begin
          stp <= stp + 2'd1;
          if (stp == 2'd3) begin
            x_q   <= mul_p + coef.c0;
            stp   <= '0;
            state <= S_ITER;
          end
        end
        S_ITER: begin
          stp <= stp + 2'd1;
          if (stp == 2'd3) begin
            x_q <= mul_p >>> 1;
            stp <= '0;
            if (it == IW'(ITERS - 1)) state <= S_DENORM;
            else                      it    <= it + 1'b1;
          end
        end
        S_DENORM: begin
          result   <= sat ? '1 : shf_v[WORD-1:0];
          overflow <= sat;
          done     <= 1'b1;
          state    <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fxp_isqrt_chk.sv
module fxp_isqrt_chk #(
  parameter int WORD  = 16,
  parameter int ITERS = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [WORD-1:0] radicand,
  input logic            busy,
  input logic            done,
  input logic [WORD-1:0] result,
  input logic            overflow
);
  localparam int LAT = 2 + 4 + 4 * ITERS;

  logic [7:0] since;
  logic       zero_seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      since     <= '0;
      zero_seen <= 1'b0;
    end else if (start && !busy) begin
      since     <= 8'd1;
      zero_seen <= (radicand == '0);
    end else if (busy) begin
      since <= since + 8'd1;
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_busy_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  assert_sat_value_R2: assert property (@(posedge clk) disable iff (rst)
    (done && overflow) |-> (result == '1));
  assert_zero_path_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && radicand == '0) |=> ##2 (done && overflow));
  assert_accept_R5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done));
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(result) && $stable(overflow)));
  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (since == (zero_seen ? 8'd3 : 8'(LAT + 1))));
endmodule

bind fxp_isqrt fxp_isqrt_chk #(.WORD(WORD), .ITERS(ITERS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .radicand(radicand),
  .busy(busy), .done(done), .result(result), .overflow(overflow)
);

// File: tb/fxp_isqrt_test.sv
module fxp_isqrt_test;
  localparam int CLK_NS = 10;
  localparam int LAT    = 14;
  localparam int WDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] radicand = '0;
  logic        busy, done, overflow;
  logic [15:0] result;

  int n_chk = 0;
  int n_bad = 0;

  fxp_isqrt uut (
    .clk(clk), .rst(rst), .start(start), .radicand(radicand),
    .busy(busy), .done(done), .result(result), .overflow(overflow)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic void ref_val(input int code, output int e, output bit eo);
    real v;
    v = 2048.0 / $sqrt(code / 2048.0);
    if (v + 0.5 >= 65536.0) begin eo = 1'b1; e = 65535; end
    else begin eo = 1'b0; e = $rtoi(v + 0.5); end
  endfunction

  task automatic run(input int code, output int res, output bit ovf, output int lat);
    @(negedge clk); start = 1'b1; radicand = 16'(code);
    @(negedge clk); start = 1'b0; lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    res = int'(result); ovf = overflow;
  endtask

  task automatic sweep_one(input int code);
    int res, lat, e; bit ovf, eo;
    run(code, res, ovf, lat);
    ref_val(code, e, eo);
    if (eo) check(ovf && res == 65535, "R2", $sformatf("saturation code %0d", code), res, 65535);
    else    check(!ovf && res >= e - 1 && res <= e + 1, "R1", $sformatf("value code %0d", code), res, e);
    check(lat == LAT, "R7", $sformatf("latency code %0d", code), lat, LAT);
    @(negedge clk);
    check(!done, "R4", "done width", int'(done), 0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
    summary();
    $finish;
  end

  initial begin
    int res, lat, dn; bit ovf;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(!busy && !done && !overflow && result == 16'd0, "R8", "reset outputs",
          int'({busy, done, overflow}) + int'(result), 0);

    // R9 reference points
    run(4096, res, ovf, lat);  check(!ovf && res >= 1447 && res <= 1449, "R9", "code 4096", res, 1448);
    run(1024, res, ovf, lat);  check(!ovf && res >= 2895 && res <= 2897, "R9", "code 1024", res, 2896);
    run(25344, res, ovf, lat); check(!ovf && res >= 581 && res <= 583, "R9", "code 25344", res, 582);

    // R10 powers of four are exact
    for (int k = 0; k < 7; k++) begin
      int code, exp;
      code = 8 << (2 * k);
      exp  = 32768 >> k;
      run(code, res, ovf, lat);
      check(!ovf && res == exp, "R10", $sformatf("exact code %0d", code), res, exp);
    end

    // R3 zero radicand
    run(0, res, ovf, lat);
    check(ovf && res == 65535, "R3", "zero saturates", res, 65535);
    check(lat == 2, "R3", "zero latency", lat, 2);

    // R2 unrepresentable results
    run(1, res, ovf, lat); check(ovf && res == 65535, "R2", "code 1", res, 65535);
    run(2, res, ovf, lat); check(ovf && res == 65535, "R2", "code 2", res, 65535);
    run(3, res, ovf, lat); check(!ovf, "R2", "code 3 representable", int'(ovf), 0);

    // R5 start while busy, and start coinciding with done
    @(negedge clk); start = 1'b1; radicand = 16'd4096;
    @(negedge clk); start = 1'b0;
    check(busy, "R5", "busy after accept", int'(busy), 1);
    repeat (4) @(negedge clk);
    start = 1'b1; radicand = 16'd1024;
    @(negedge clk); start = 1'b0;
    dn = 0; lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    if (done) dn++;
    check(result >= 16'd1447 && result <= 16'd1449, "R5", "mid-run start ignored", int'(result), 1448);
    start = 1'b1; radicand = 16'd25344;
    @(negedge clk); start = 1'b0;
    check(!busy, "R5", "start in done cycle ignored", int'(busy), 0);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (done) dn++; end
    check(dn == 1, "R5", "single done pulse", dn, 1);

    // R6 outputs held while idle
    for (int i = 0; i < 5; i++) begin
      radicand = 16'(i * 7919 + 3);
      @(negedge clk);
      check(result >= 16'd1447 && result <= 16'd1449 && !overflow, "R6", "idle hold",
            int'(result), 1448);
    end

    // R1 / R2 / R7 near-exhaustive sweep
    for (int c = 1; c <= 600; c++) sweep_one(c);
    for (int c = 601; c <= 65535; c += 37) sweep_one(c);
    sweep_one(65535);

    summary();
    $finish;
  end
endmodule